// File: doc/BRIEF.md
# Turbo Permuter Address Generator

This block produces, one per request, the read positions that a turbo encoder's second constituent encoder uses to fetch information bits from the frame buffer in permuted order. For a frame of k bits it walks the index s from 1 to k and emits the permuted bit position for each s. It does this through the closed-form row/column permutation rule, with the k = k1·k2 factorisation and a small table of eight primes. No permutation table is stored.

A consumer selects one of five frame lengths and pulses `start`. The first position is presented one cycle later with `addr_valid` high, and is held until the consumer raises `advance`. Each accepted `advance` moves to the next index. The final position carries `addr_last`, and accepting it returns the block to idle. The row counter, the column counter and the even/odd phase are kept as running counters. The column product modulo k2 is built up by adding the row prime and doing one conditional subtraction per step, so no divider or multiplier is needed.

Top module: `turbo_perm_addr_gen`

## Requirements
- R1: `blk_sel` selects the frame length k: 0 gives 1784 (k1=8, k2=223), 1 gives 3568 (k2=446), 2 gives 7136 (k2=892), 3 gives 8920 (k2=1115), 4 gives 16384 (k1=k2=128). A `start` with code 5, 6 or 7 is ignored, whether the block is idle or busy.
- R2: A `start` with a legal code raises `addr_valid` on the next cycle and presents the position for s=1, which is 4 with 1-based numbering.
- R3: The position for index s is 2·(t + c·k1/2 + 1) − m. Here m = (s−1) mod 2, i = floor((s−1)/(2·k2)), j = floor((s−1)/2) − i·k2, t = (19·i+1) mod (k1/2), and c = (p·j + 21·m) mod k2. The prime p is entry (t mod 8) of the list 31, 37, 43, 47, 53, 59, 61, 67, counting from entry 0.
- R4: While `addr_valid` is high and `advance` is low, `addr`, `addr_valid` and `addr_last` hold their values.
- R5: `addr_last` is high exactly while the presented index is s = k, and never while `addr_valid` is low.
- R6: An `advance` accepted on the last position drops `addr_valid` on the next cycle. An `advance` while `addr_valid` is low has no effect.
- R7: A legal `start` while a frame is in progress restarts the sequence at s=1 with the new length. It takes priority over an `advance` in the same cycle.
- R8: With parameter `ZERO_BASED` = 1, every emitted position is one less than the 1-based value.
- R9: While `rst_n` is low at a clock edge, `addr_valid` and `addr_last` are low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_sel | input | 3 | Frame length code, sampled with `start` |
| start | input | 1 | Begin (or restart) a permutation walk |
| advance | input | 1 | Accept the current position and move to the next |
| addr | output | 15 | Permuted bit position of the current index |
| addr_valid | output | 1 | `addr` holds a position to be consumed |
| addr_last | output | 1 | Current position is the final one of the frame |

## Verification
Two events can meet in one cycle: a fresh legal `start` and an `advance` on a walk already in progress. The bench moves a short frame ten steps in, then raises both in the same cycle with a different length code. It expects the first two positions of the new frame, computed from the formula, and `addr_last` low. It also sends an illegal-code `start` together with an `advance` mid-walk, and expects the step to happen as if the `start` were absent. Full walks of all five lengths, with periodic stalls, are compared against an independent formula model. A second instance with 0-based numbering is compared alongside.

// File: rtl/perm_pkg.sv
// Shared widths, configuration record and prime list for the permuter
// address generator. Assumes at most 16384 information bits per frame.
package perm_pkg;

    localparam int SEL_W  = 3;   // length-code width
    localparam int K_W    = 15;  // holds k up to 16384
    localparam int K2_W   = 11;  // holds k2 up to 1115
    localparam int T_W    = 6;   // holds t below k1/2 = 64
    localparam int P_W    = 7;   // holds primes up to 67
    localparam int ROW_STEP = 19;
    localparam int ODD_OFFSET = 21;

    typedef struct packed {
        logic [K_W-1:0]  k;     // frame length
        logic [K2_W-1:0] k2;    // column count
        logic            wide;  // 1: k1 = 128, 0: k1 = 8
    } perm_cfg_t;

    // Prime multiplier chosen by the low three bits of t.
    function automatic logic [P_W-1:0] prime_at(input logic [2:0] idx);
        case (idx)
            3'd0: prime_at = P_W'(31);
            3'd1: prime_at = P_W'(37);
            3'd2: prime_at = P_W'(43);
            3'd3: prime_at = P_W'(47);
            3'd4: prime_at = P_W'(53);
            3'd5: prime_at = P_W'(59);
            3'd6: prime_at = P_W'(61);
            default: prime_at = P_W'(67);
        endcase
    endfunction

endpackage

// File: rtl/perm_cfg.sv
// Decodes the length code into k, k2 and the k1 variant.
// Assumes codes above 4 are illegal; reports them through sel_ok.
module perm_cfg
    import perm_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output perm_cfg_t        cfg,
    output logic             sel_ok
);

    // Table of the five legal frame lengths.
    always_comb begin
        sel_ok = 1'b1;
        cfg.wide = 1'b0;
        case (sel)
            3'd0: begin cfg.k = K_W'(1784);  cfg.k2 = K2_W'(223);  end
            3'd1: begin cfg.k = K_W'(3568);  cfg.k2 = K2_W'(446);  end
            3'd2: begin cfg.k = K_W'(7136);  cfg.k2 = K2_W'(892);  end
            3'd3: begin cfg.k = K_W'(8920);  cfg.k2 = K2_W'(1115); end
            3'd4: begin cfg.k = K_W'(16384); cfg.k2 = K2_W'(128); cfg.wide = 1'b1; end
            default: begin
                cfg.k = K_W'(16384); cfg.k2 = K2_W'(128); cfg.wide = 1'b1;
                sel_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/perm_walk.sv
// Index walker: keeps s, the even/odd phase m, the column j, the row
// term t and the running product (p*j) mod k2. Assumes cfg is stable
// between load and the end of the frame, and that every prime is < k2.
module perm_walk
    import perm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  perm_cfg_t       cfg,
    output logic [K_W-1:0]  pos,
    output logic            odd,
    output logic [T_W-1:0]  row_t,
    output logic [K2_W-1:0] acc
);

    logic [K_W-1:0]  pos_q;
    logic            odd_q;
    logic [K2_W-1:0] col_q;
    logic [T_W-1:0]  t_q;
    logic [K2_W-1:0] acc_q;
    logic [T_W-1:0]  t_mask;
    logic [K2_W:0]   acc_sum;
    logic [K2_W-1:0] acc_next;
    logic [T_W-1:0]  t_next;
    logic            row_end;

    // Next values for the product accumulator and the row term.
    always_comb begin
        t_mask   = cfg.wide ? T_W'(63) : T_W'(3);
        acc_sum  = {1'b0, acc_q} + (K2_W+1)'(prime_at(t_q[2:0]));
        acc_next = (acc_sum >= {1'b0, cfg.k2}) ? K2_W'(acc_sum - {1'b0, cfg.k2})
                                              : acc_sum[K2_W-1:0];
        t_next   = (t_q + T_W'(ROW_STEP)) & t_mask;
        row_end  = (col_q == cfg.k2 - K2_W'(1));
    end

    // Counter state: reset, load for s=1, or move one index forward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            odd_q <= 1'b0;
            col_q <= '0;
            t_q   <= '0;
            acc_q <= '0;
        end else if (load) begin
            pos_q <= K_W'(1);
            odd_q <= 1'b0;
            col_q <= '0;
            t_q   <= T_W'(1);
            acc_q <= '0;
        end else if (step) begin
            pos_q <= pos_q + K_W'(1);
            odd_q <= ~odd_q;
            if (odd_q) begin
                if (row_end) begin
                    col_q <= '0;
                    t_q   <= t_next;
                    acc_q <= '0;
                end else begin
                    col_q <= col_q + K2_W'(1);
                    acc_q <= acc_next;
                end
            end
        end
    end

    assign pos   = pos_q;
    assign odd   = odd_q;
    assign row_t = t_q;
    assign acc   = acc_q;

    // R3: the running product and the column stay reduced below k2.
    assert_acc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.k2 != '0) |-> (acc_q < cfg.k2 && col_q < cfg.k2));

    // R3: the row term never leaves the range 0..k1/2-1.
    assert_row_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.wide |-> (t_q < T_W'(4)));

endmodule

// File: rtl/perm_addr_map.sv
// Forms the bit position from the walker state: adds the odd-phase
// offset modulo k2, scales by k1/2, adds t and applies 2x(.)+2-m.
// Assumes acc < k2 and t < k1/2, so one subtraction reduces c.
module perm_addr_map
    import perm_pkg::*;
#(
    parameter int ADDR_W     = K_W,
    parameter bit ZERO_BASED = 1'b0
) (
    input  perm_cfg_t        cfg,
    input  logic             odd,
    input  logic [T_W-1:0]   row_t,
    input  logic [K2_W-1:0]  acc,
    output logic [ADDR_W-1:0] addr
);

    logic [K2_W:0]     c_sum;
    logic [K2_W-1:0]   col;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] one_based;

    // Column, base offset and 1-based position.
    always_comb begin
        c_sum = {1'b0, acc} + (odd ? (K2_W+1)'(ODD_OFFSET) : '0);
        col   = (c_sum >= {1'b0, cfg.k2}) ? K2_W'(c_sum - {1'b0, cfg.k2})
                                         : c_sum[K2_W-1:0];
        base  = ADDR_W'(row_t) + (cfg.wide ? (ADDR_W'(col) << 6) : (ADDR_W'(col) << 2));
        one_based = ((base + ADDR_W'(1)) << 1) - ADDR_W'(odd);
    end

    generate
        if (ZERO_BASED) begin : g_zero
            assign addr = one_based - ADDR_W'(1);
        end else begin : g_one
            assign addr = one_based;
        end
    endgenerate

endmodule

// File: rtl/turbo_perm_addr_gen.sv
// Top: latches the frame configuration on start, tracks the valid/last
// handshake and ties the walker to the position formula.
// Assumes the consumer holds advance only as long as it wants positions.
module turbo_perm_addr_gen
    import perm_pkg::*;
#(
    parameter bit ZERO_BASED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] blk_sel,
    input  logic             start,
    input  logic             advance,
    output logic [K_W-1:0]   addr,
    output logic             addr_valid,
    output logic             addr_last
);

    localparam int ADDR_W = K_W;
    localparam logic [ADDR_W-1:0] FIRST_POS = ZERO_BASED ? ADDR_W'(3) : ADDR_W'(4);

    perm_cfg_t        sel_cfg;
    logic             sel_ok;
    perm_cfg_t        cfg_q;
    logic             valid_q;
    logic             load;
    logic             step;
    logic             at_end;
    logic [K_W-1:0]   pos;
    logic             odd;
    logic [T_W-1:0]   row_t;
    logic [K2_W-1:0]  acc;

    perm_cfg u_cfg (
        .sel    (blk_sel),
        .cfg    (sel_cfg),
        .sel_ok (sel_ok)
    );

    // Handshake decisions: a legal start wins over advance.
    always_comb begin
        load   = start && sel_ok;
        at_end = valid_q && (pos == cfg_q.k);
        step   = valid_q && advance && !load && !at_end;
    end

    // Configuration latch and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            cfg_q   <= sel_cfg;
            valid_q <= 1'b1;
        end else if (at_end && advance) begin
            valid_q <= 1'b0;
        end
    end

    perm_walk u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .cfg   (cfg_q),
        .pos   (pos),
        .odd   (odd),
        .row_t (row_t),
        .acc   (acc)
    );

    perm_addr_map #(.ADDR_W(ADDR_W), .ZERO_BASED(ZERO_BASED)) u_map (
        .cfg   (cfg_q),
        .odd   (odd),
        .row_t (row_t),
        .acc   (acc),
        .addr  (addr)
    );

    assign addr_valid = valid_q;
    assign addr_last  = at_end;

    // R2: a legal start presents the s=1 position next cycle.
    assert_first_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && sel_ok) |=> (addr_valid && addr == FIRST_POS));

    // R3: every presented position lies within the frame.
    assert_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> ((32'(addr) + 32'(ZERO_BASED)) >= 32'd1 &&
                        (32'(addr) + 32'(ZERO_BASED)) <= 32'(cfg_q.k)));

    // R4: a stalled position is held.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !advance && !start) |=> (addr_valid && $stable(addr) && $stable(addr_last)));

    // R5: last only accompanies a valid position.
    assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_last |-> addr_valid);

    // R6: accepting the last position ends the frame.
    assert_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_last && advance && !start) |=> !addr_valid);

    // R9: reset clears the handshake outputs.
    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (!addr_valid && !addr_last));

endmodule

// File: tb/turbo_perm_addr_gen_test.sv
`timescale 1ns/1ps
module turbo_perm_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  blk_sel = '0;
    logic        start = 1'b0;
    logic        advance = 1'b0;
    logic [14:0] addr, addr0;
    logic        addr_valid, addr_last, valid0, last0;

    int n_checks = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    int exp_addr[$];
    bit exp_last[$];

    always #10 clk = ~clk;  // 50 MHz

    turbo_perm_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .blk_sel(blk_sel), .start(start),
        .advance(advance), .addr(addr), .addr_valid(addr_valid), .addr_last(addr_last)
    );

    turbo_perm_addr_gen #(.ZERO_BASED(1'b1)) uut0 (
        .clk(clk), .rst_n(rst_n), .blk_sel(blk_sel), .start(start),
        .advance(advance), .addr(addr0), .addr_valid(valid0), .addr_last(last0)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void dims(input int sel, output int k1, output int k2);
        case (sel)
            0: begin k1 = 8; k2 = 223; end
            1: begin k1 = 8; k2 = 446; end
            2: begin k1 = 8; k2 = 892; end
            3: begin k1 = 8; k2 = 1115; end
            default: begin k1 = 128; k2 = 128; end
        endcase
    endfunction

    // Reference position straight from the division form of the rule.
    function automatic int ref_pos(input int k1, input int k2, input int s);
        int primes[8] = '{31, 37, 43, 47, 53, 59, 61, 67};
        int m = (s - 1) % 2;
        int i = (s - 1) / (2 * k2);
        int j = (s - 1) / 2 - i * k2;
        int t = (19 * i + 1) % (k1 / 2);
        int c = (primes[t % 8] * j + 21 * m) % k2;
        return 2 * (t + c * (k1 / 2) + 1) - m;
    endfunction

    // Monitor: compares each presented position with the queue front.
    always begin
        @(negedge clk);
        #5;
        if (mon_en && addr_valid) begin
            if (exp_addr.size() == 0) begin
                check(1'b0, "R3 unexpected position", int'(addr), -1);
            end else begin
                check(int'(addr) == exp_addr[0], "R3 position", int'(addr), exp_addr[0]);
                check(addr_last == exp_last[0], "R5 last flag", int'(addr_last), int'(exp_last[0]));
                check(valid0 && int'(addr0) == exp_addr[0] - 1, "R8 zero-based", int'(addr0), exp_addr[0] - 1);
                if (advance) begin
                    void'(exp_addr.pop_front());
                    void'(exp_last.pop_front());
                end
            end
        end
    end

    // Driver: queues a whole frame, starts it and consumes with stalls (R4).
    task automatic sweep(input int sel);
        int k1, k2, k, cyc;
        dims(sel, k1, k2);
        k = k1 * k2;
        for (int s = 1; s <= k; s++) begin
            exp_addr.push_back(ref_pos(k1, k2, s));
            exp_last.push_back(s == k);
        end
        @(negedge clk);
        blk_sel = 3'(sel); start = 1'b1; advance = 1'b0; mon_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (exp_addr.size() > 0) begin
            advance = (cyc % 5 != 3);
            cyc++;
            @(negedge clk);
        end
        advance = 1'b0; mon_en = 1'b0;
        #5;
        check(!addr_valid && !addr_last, "R6 idle after last", int'(addr_valid), 0);
        @(negedge clk);
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        #5;
        check(!addr_valid, "R6 advance while idle ignored", int'(addr_valid), 0);
    endtask

    initial begin : watchdog
        #(20ns * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int v;
        repeat (3) @(negedge clk);
        #5;
        check(!addr_valid && !addr_last, "R9 reset outputs", int'(addr_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: illegal code from idle.
        @(negedge clk);
        blk_sel = 3'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #5;
        check(!addr_valid, "R1 illegal code ignored", int'(addr_valid), 0);

        // R2 explicit first position.
        @(negedge clk);
        blk_sel = 3'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #5;
        check(addr_valid && int'(addr) == 4, "R2 first position", int'(addr), 4);

        // R7: ten steps in, then start and advance together with a new length.
        @(negedge clk);
        advance = 1'b1;
        repeat (10) @(negedge clk);
        check(1'b1, "R7 setup", 0, 0);
        blk_sel = 3'd4; start = 1'b1; advance = 1'b1;
        @(negedge clk);
        start = 1'b0; advance = 1'b0;
        #5;
        v = ref_pos(128, 128, 1);
        check(addr_valid && int'(addr) == v, "R7 restart wins", int'(addr), v);
        check(!addr_last, "R7 last low after restart", int'(addr_last), 0);
        @(negedge clk);
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        #5;
        v = ref_pos(128, 128, 2);
        check(int'(addr) == v, "R7 second position of new frame", int'(addr), v);

        // R1: illegal start while busy, alone and with advance.
        @(negedge clk);
        blk_sel = 3'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #5;
        check(addr_valid && int'(addr) == v, "R1 illegal start while busy", int'(addr), v);
        @(negedge clk);
        blk_sel = 3'd6; start = 1'b1; advance = 1'b1;
        @(negedge clk);
        start = 1'b0; advance = 1'b0;
        #5;
        v = ref_pos(128, 128, 3);
        check(int'(addr) == v, "R1 illegal start does not block advance", int'(addr), v);

        // R9: reset mid-frame.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #5;
        check(!addr_valid && !addr_last, "R9 reset mid-frame", int'(addr_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3, R4, R5, R6, R8: full frames of every length.
        for (int sel = 0; sel < 5; sel++) sweep(sel);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule